// File: doc/BRIEF.md
# Address Line Permutation Recovery Engine

This block works out how the address lines of a one-bit-wide memory were reordered after the memory was filled. The memory holds a fixed probe pattern. When the lines are shuffled by an unknown permutation, a read at logical address x returns the stored bit at the physical address formed by moving logical bit i to position perm(i). The engine issues a planned series of reads. From the returned bits it rebuilds perm(j) for every line j and presents the result as a flat table.

Recovery runs one bit of every table entry at a time. Round 0 finds bit 0 of each entry. Round k uses the low k bits already learned to choose its probe addresses, so that each read reveals bit k of one line's entry. With LINES lines and W = log2(LINES), the engine needs exactly LINES*W reads. An optional variant infers the last read of each round. That read is implied because, inside any residue class of 0..LINES-1 modulo 2^k, exactly half of the values have bit k set.

The memory may answer any number of cycles after a request. The engine keeps one read in flight and waits for the valid strobe.

Top module: `perm_recover`

## Requirements
- R1: After reset, done and rd_req are low and perm_out is all zeros.
- R2: In round 0, the probe for line j drives exactly one address bit high, bit j. The returned bit becomes bit 0 of entry j.
- R3: In round k >= 1, the probe for line j drives high line j and every line whose learned value modulo 2^k equals (z-1) mod 2^k, where z is line j's learned value modulo 2^k. The probe therefore has LINES/2^k + 1 ones. The returned bit becomes bit k of entry j.
- R4: When done pulses, perm_out[j*W +: W] equals perm(j) for every line j.
- R5: done is high for exactly one cycle, in the cycle after the last bit is captured. perm_out then holds its value until the next accepted start.
- R6: At most one read is outstanding at a time. A read is completed only by rd_valid, whatever the memory latency. Without skipping, a run issues exactly LINES*W reads.
- R7: With SKIP_LAST set, the last line of each round is not read and its bit is inferred. A run issues LINES*W - W reads and still recovers the permutation.
- R8: A start pulse during a run is ignored. The run's reads and result are unchanged.
- R9: An accepted start clears perm_out to zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a recovery run when idle |
| rd_req | output | 1 | Read request strobe, one cycle |
| rd_addr | output | LINES | Logical read address, valid with rd_req |
| rd_valid | input | 1 | Read data strobe |
| rd_bit | input | 1 | Returned memory bit |
| perm_out | output | LINES*W | Entry j at bits [j*W +: W] holds perm(j) |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every permutation of four lines is run, both with full reads and with inferred last reads. A design that mis-steers a probe then lands on an unwritten location, which the memory model flags. A design that computes the inferred bit wrongly corrupts some entries. An eight-line instance whose memory answers two cycles late takes random permutations. This catches a design that captures data on a fixed cycle count instead of on rd_valid. Starts injected mid-run and a check of the table right after start expose a restart or a missing clear.

// File: rtl/perm_recover.sv
module perm_recover #(
  parameter int LINES = 8,
  parameter bit SKIP_LAST = 1'b0,
  localparam int W = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               rd_req,
  output logic [LINES-1:0]   rd_addr,
  input  logic               rd_valid,
  input  logic               rd_bit,
  output logic [LINES*W-1:0] perm_out,
  output logic               done
);
  logic [LINES-1:0][W-1:0] tbl;
  logic [W-1:0] round, line, mask, z, zm1;
  logic [W:0]   cnt;
  logic running, waiting, last_line, skip, advance, infer, bit_in;

  assign mask      = W'((32'd1 << round) - 32'd1);
  assign z         = tbl[line] & mask;
  assign zm1       = (z - 1'b1) & mask;
  assign last_line = line == W'(LINES - 1);
  assign skip      = SKIP_LAST && last_line;
  assign rd_req    = running && !waiting && !skip;
  assign advance   = running && (waiting ? rd_valid : skip);
  assign infer     = 32'(cnt) != (LINES >> (32'(round) + 1));
  assign bit_in    = waiting ? rd_bit : infer;
  assign perm_out  = tbl;

  always_comb begin
    for (int i = 0; i < LINES; i++)
      rd_addr[i] = (W'(i) == line) || (round != '0 && (tbl[i] & mask) == zm1);
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < LINES; i++)
      if (W'(i) != line && (tbl[i] & mask) == z && tbl[i][round])
        cnt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl     <= '0;
      round   <= '0;
      line    <= '0;
      running <= 1'b0;
      waiting <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!running) begin
        if (start) begin
          tbl     <= '0;
          round   <= '0;
          line    <= '0;
          running <= 1'b1;
          waiting <= 1'b0;
        end
      end else begin
        if (rd_req) waiting <= 1'b1;
        if (advance) begin
          tbl[line][round] <= bit_in;
          waiting <= 1'b0;
          if (last_line) begin
            line <= '0;
            if (round == W'(W - 1)) begin
              running <= 1'b0;
              done    <= 1'b1;
            end else begin
              round <= round + 1'b1;
            end
          end else begin
            line <= line + 1'b1;
          end
        end
      end
    end
  end
endmodule

module perm_recover_chk #(
  parameter int LINES = 8,
  localparam int W = $clog2(LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               rd_req,
  input logic [LINES-1:0]   rd_addr,
  input logic               done,
  input logic [LINES*W-1:0] perm_out,
  input logic               running,
  input logic [W-1:0]       round
);
  // R2
  probe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && round == '0 |-> $countones(rd_addr) == 1);
  // R3
  probe_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && round != '0 |-> $countones(rd_addr) == (LINES >> round) + 1);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !start |=> $stable(perm_out));
  // R6
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && start |=> running || done);
  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !running |=> perm_out == '0);
endmodule

bind perm_recover perm_recover_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
  .done(done), .perm_out(perm_out), .running(running), .round(round));

// File: tb/perm_recover_tb.sv
module perm_mem_model #(
  parameter int LINES = 4,
  parameter int LAT = 1,
  localparam int W = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES*W-1:0] perm,
  input  logic               rd_req,
  input  logic [LINES-1:0]   rd_addr,
  output logic               rd_valid,
  output logic               rd_bit,
  output int                 reqs,
  output int                 bad
);
  logic vp [LAT];
  logic bp [LAT];
  logic [1:0] res;

  function automatic logic [1:0] look(input logic [LINES-1:0] y);
    int w, m, full, p, np;
    w = $countones(y);
    if (w == 1) begin
      for (int i = 0; i < LINES; i++) if (y[i]) return {1'b1, 1'(i & 1)};
    end
    for (int k = 1; k < W; k++) begin
      if (w == (LINES >> k) + 1) begin
        m = (1 << k) - 1;
        full = -1;
        for (int c = 0; c <= m; c++) begin
          int n = 0;
          for (int i = 0; i < LINES; i++) if (y[i] && (i & m) == c) n++;
          if (n == (LINES >> k)) full = c;
        end
        if (full < 0) return 2'b00;
        np = 0; p = 0;
        for (int i = 0; i < LINES; i++)
          if (y[i] && (i & m) != full) begin np++; p = i; end
        if (np != 1 || (p & m) != ((full + 1) & m)) return 2'b00;
        return {1'b1, 1'((p >> k) & 1)};
      end
    end
    return 2'b00;
  endfunction

  always_comb begin
    logic [LINES-1:0] y;
    y = '0;
    for (int i = 0; i < LINES; i++) y[perm[i*W +: W]] = rd_addr[i];
    res = look(y);
  end

  assign rd_valid = vp[LAT-1];
  assign rd_bit   = bp[LAT-1];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) begin vp[s] <= 1'b0; bp[s] <= 1'b0; end
      reqs <= 0;
      bad  <= 0;
    end else begin
      vp[0] <= rd_req;
      bp[0] <= rd_req & res[0];
      for (int s = 1; s < LAT; s++) begin vp[s] <= vp[s-1]; bp[s] <= bp[s-1]; end
      if (rd_req) begin
        reqs <= reqs + 1;
        if (!res[1]) bad <= bad + 1;
      end
    end
  end
endmodule

module perm_recover_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_a = 1'b0, st_b = 1'b0, st_c = 1'b0;
  logic [7:0]  pm_a = '0, pm_b = '0;
  logic [23:0] pm_c = '0;
  logic rq_a, rq_b, rq_c, vl_a, vl_b, vl_c, bt_a, bt_b, bt_c, dn_a, dn_b, dn_c;
  logic [3:0] ad_a, ad_b;
  logic [7:0] ad_c;
  logic [7:0]  po_a, po_b;
  logic [23:0] po_c;
  int rc_a, rc_b, rc_c, bd_a, bd_b, bd_c;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_recover #(.LINES(4)) u_dut (.clk(clk), .rst_n(rst_n), .start(st_a), .rd_req(rq_a),
    .rd_addr(ad_a), .rd_valid(vl_a), .rd_bit(bt_a), .perm_out(po_a), .done(dn_a));
  perm_mem_model #(.LINES(4), .LAT(1)) u_mem_a (.clk(clk), .rst_n(rst_n), .perm(pm_a),
    .rd_req(rq_a), .rd_addr(ad_a), .rd_valid(vl_a), .rd_bit(bt_a), .reqs(rc_a), .bad(bd_a));

  perm_recover #(.LINES(4), .SKIP_LAST(1'b1)) u_dut_skip (.clk(clk), .rst_n(rst_n), .start(st_b),
    .rd_req(rq_b), .rd_addr(ad_b), .rd_valid(vl_b), .rd_bit(bt_b), .perm_out(po_b), .done(dn_b));
  perm_mem_model #(.LINES(4), .LAT(3)) u_mem_b (.clk(clk), .rst_n(rst_n), .perm(pm_b),
    .rd_req(rq_b), .rd_addr(ad_b), .rd_valid(vl_b), .rd_bit(bt_b), .reqs(rc_b), .bad(bd_b));

  perm_recover #(.LINES(8)) u_dut_wide (.clk(clk), .rst_n(rst_n), .start(st_c), .rd_req(rq_c),
    .rd_addr(ad_c), .rd_valid(vl_c), .rd_bit(bt_c), .perm_out(po_c), .done(dn_c));
  perm_mem_model #(.LINES(8), .LAT(2)) u_mem_c (.clk(clk), .rst_n(rst_n), .perm(pm_c),
    .rd_req(rq_c), .rd_addr(ad_c), .rd_valid(vl_c), .rd_bit(bt_c), .reqs(rc_c), .bad(bd_c));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint getp(input int s);
    case (s) 0: return longint'(po_a); 1: return longint'(po_b); default: return longint'(po_c); endcase
  endfunction
  function automatic logic getd(input int s);
    case (s) 0: return dn_a; 1: return dn_b; default: return dn_c; endcase
  endfunction
  function automatic int getr(input int s);
    case (s) 0: return rc_a; 1: return rc_b; default: return rc_c; endcase
  endfunction
  function automatic int getb(input int s);
    case (s) 0: return bd_a; 1: return bd_b; default: return bd_c; endcase
  endfunction
  task automatic set_start(input int s, input logic v);
    case (s) 0: st_a = v; 1: st_b = v; default: st_c = v; endcase
  endtask

  task automatic run(input int s, input longint exp, input int nreads, input bit poke);
    int r0, b0, n;
    longint held;
    r0 = getr(s); b0 = getb(s);
    @(negedge clk); set_start(s, 1'b1);
    @(negedge clk); set_start(s, 1'b0);
    // R9: table cleared after start
    chk(getp(s) == 0, "R9", getp(s), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      set_start(s, 1'b1);
      @(negedge clk); set_start(s, 1'b0);
    end
    n = 0;
    while (!getd(s) && n < 3000) begin @(negedge clk); n++; end
    chk(getd(s), "R5", 0, 1);
    // R4 / R8: recovered table
    chk(getp(s) == exp, poke ? "R8" : "R4", getp(s), exp);
    // R6 / R7: read count
    chk(getr(s) - r0 == nreads, s == 1 ? "R7" : "R6", getr(s) - r0, nreads);
    // R2 / R3: every probe hit a written pattern
    chk(getb(s) == b0, "R3", getb(s) - b0, 0);
    held = getp(s);
    @(negedge clk);
    chk(!getd(s), "R5", getd(s), 0);
    @(negedge clk);
    chk(getp(s) == held, "R5", getp(s), held);
  endtask

  initial begin
    while (cycles < WATCHDOG) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(dn_a == 1'b0, "R1", dn_a, 0);
    chk(rq_a == 1'b0, "R1", rq_a, 0);
    chk(po_a == '0, "R1", po_a, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              logic [7:0] p;
              p = {2'(d), 2'(c), 2'(b), 2'(a)};
              pm_a = p; pm_b = p;
              run(0, longint'(p), 8, (a == 2 && b == 0));
              run(1, longint'(p), 6, 1'b0);
            end
    for (int t = 0; t < 100; t++) begin
      int v [8];
      logic [23:0] p;
      for (int i = 0; i < 8; i++) v[i] = i;
      for (int i = 7; i > 0; i--) begin
        int j, tmp;
        j = int'($urandom % (i + 1));
        tmp = v[i]; v[i] = v[j]; v[j] = tmp;
      end
      for (int i = 0; i < 8; i++) p[i*3 +: 3] = 3'(v[i]);
      pm_c = p;
      run(2, longint'(p), 24, t == 5);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule